// File: doc/BRIEF.md
# Lane-Masked Warp Execution Unit

This block executes one instruction stream across a warp of 32 lanes in lock-step. Every lane holds a private file of 64 registers, each 32 bits wide, and applies the same integer operation to its own operands. An active-lane mask gates which lanes commit results. Lanes outside the mask perform no write, but the warp still spends the cycle on the instruction.

Structured control flow is supported by a divergence stack. A conditional with lanes on both sides runs the then-path with its lanes enabled, then the else-path with the remaining lanes, and restores the saved mask at the join point. Loops whose trip count differs per lane keep iterating until the last lane leaves. A pair of counters records issued cycles and the sum of active lanes, so that utilisation can be measured.

The surrounding logic supplies the instruction addressed by `pc` on the same cycle. It launches a run with `start` and a lane mask, and reads any lane register through a side read port.

Top module: `simt_warp_unit`

## Requirements
- R1: Instruction word: opcode in bits [31:28], destination in [27:22], first source in [21:16], second source in [15:10], immediate/target in [9:0]. Opcodes: 0 no-op, 1 add, 2 subtract, 3 and, 4 or, 5 xor, 6 signed less-than (writes 1 or 0), 7 load zero-extended immediate, 8 load lane index, 9 conditional split, 10 else, 11 join, 12 loop open, 13 loop back, 14 halt.
- R2: Each arithmetic, logic, compare or load opcode updates the destination register in every active lane, using that lane's own operand values, in the cycle it is issued.
- R3: A lane whose mask bit is clear keeps its registers unchanged, and the instruction still counts as one issued cycle.
- R4: A split (opcode 9, target T) whose source is nonzero in some but not all active lanes pushes one stack entry and runs the next instructions with only the nonzero lanes. The else (opcode 10) at address T-1 then switches to the remaining lanes, and the join (opcode 11) at the address named by the else pops the entry and restores the full saved mask.
- R5: A split whose condition is uniform over the active lanes pushes nothing. When all lanes are true, it falls through and the else jumps to its target. When all are false, it jumps straight to T.
- R6: A loop open (opcode 12) saves the mask. A loop back (opcode 13, target T) keeps only the lanes whose source is nonzero and jumps to T while any remain. When none remain, it pops the entry, restores the saved mask and falls through.
- R7: Each issued instruction adds 1 to `cycle_count` and adds the number of set mask bits at issue to `lane_count`.
- R8: With an all-zero active mask, no register is written and the program counter still advances past non-control instructions.
- R9: After reset: `pc` is 0, `running` is low, both counters and `stack_depth` are 0, and every lane register reads 0.
- R10: `start` loads `start_mask` as the active mask, sets `pc` to 0, empties the stack, clears both counters and begins issuing on the following cycle.
- R11: Halt (opcode 14) is counted as issued, then stops issue. While stopped, `pc` and the counters hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a run from address 0 |
| start_mask | input | 32 | Lanes enabled at launch |
| instr | input | 32 | Instruction at address `pc` |
| pc | output | 10 | Current instruction address |
| running | output | 1 | Unit is issuing instructions |
| active_mask | output | 32 | Current active-lane mask |
| stack_depth | output | 4 | Entries on the divergence stack |
| cycle_count | output | 32 | Issued instructions since launch |
| lane_count | output | 32 | Summed active lanes since launch |
| rd_lane | input | 5 | Lane selected for register read |
| rd_reg | input | 6 | Register selected for read |
| rd_data | output | 32 | Selected lane register value |

## Verification
The sharpest collision is a control instruction that changes the mask in the same cycle in which the counter samples it. This happens at the final loop back, which pops the stack and restores lanes, and at the join, which restores lanes while being issued under the narrowed mask. A loop whose lanes run one to four iterations provokes both. The expected `lane_count` is computed by hand from the per-iteration lane populations, so the counter must have used the pre-change mask. The restored `active_mask` and the per-lane iteration counts in the registers confirm the pop.

// File: rtl/simt_pkg.sv
package simt_pkg;

  localparam int DATA_W = 32;
  localparam int OP_W   = 4;
  localparam int REG_W  = 6;
  localparam int IMM_W  = 10;
  localparam int PC_W   = IMM_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_SLT   = 4'd6,
    OP_LDI   = 4'd7,
    OP_LID   = 4'd8,
    OP_SPLIT = 4'd9,
    OP_ELSE  = 4'd10,
    OP_JOIN  = 4'd11,
    OP_LOPEN = 4'd12,
    OP_LBACK = 4'd13,
    OP_HALT  = 4'd14
  } op_e;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [IMM_W-1:0] imm;
  } instr_t;

  // True for opcodes that write a destination register
  function automatic logic op_writes(input logic [OP_W-1:0] op);
    return (op >= OP_ADD) && (op <= OP_LID);
  endfunction

  // True for opcodes that may redirect the program counter or mask
  function automatic logic op_is_ctrl(input logic [OP_W-1:0] op);
    return (op >= OP_SPLIT) && (op <= OP_HALT);
  endfunction

  // Per-lane result of one data opcode
  function automatic logic [DATA_W-1:0] alu_eval(
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [IMM_W-1:0]  imm,
    input logic [DATA_W-1:0] lane_id
  );
    logic [DATA_W-1:0] r;
    case (op)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_SLT:  r = ($signed(a) < $signed(b)) ? DATA_W'(1) : '0;
      OP_LDI:  r = DATA_W'(imm);
      OP_LID:  r = lane_id;
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/simt_lane.sv
module simt_lane
  import simt_pkg::*;
#(
  parameter int LANE_ID = 0,
  parameter int NREG    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  instr_t            ins,
  input  logic [REG_W-1:0]  dbg_sel,
  output logic              cond_nz,
  output logic [DATA_W-1:0] dbg_data
);

  logic [DATA_W-1:0] rf [NREG];
  logic [DATA_W-1:0] opa, opb, res;

  assign opa      = rf[ins.rs1];
  assign opb      = rf[ins.rs2];
  assign cond_nz  = (opa != '0);
  assign res      = alu_eval(ins.op, opa, opb, ins.imm, DATA_W'(LANE_ID));
  assign dbg_data = rf[dbg_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (we) begin
      rf[ins.rd] <= res;
    end
  end

endmodule

// File: rtl/simt_div_stack.sv
module simt_div_stack
  import simt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LANES = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int SDW  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic             mark,
  input  logic [LANES-1:0] push_saved,
  input  logic [LANES-1:0] push_other,
  input  logic [PC_W-1:0]  push_else_pc,
  input  logic             push_loop,
  input  logic [PC_W-1:0]  mark_join,
  output logic [LANES-1:0] top_saved,
  output logic [LANES-1:0] top_other,
  output logic [PC_W-1:0]  top_else_pc,
  output logic [PC_W-1:0]  top_join,
  output logic             top_pend,
  output logic             top_loop,
  output logic [SDW-1:0]   depth,
  output logic             empty,
  output logic             full
);

  logic [LANES-1:0] saved_q [DEPTH];
  logic [LANES-1:0] other_q [DEPTH];
  logic [PC_W-1:0]  else_q  [DEPTH];
  logic [PC_W-1:0]  join_q  [DEPTH];
  logic [DEPTH-1:0] pend_q;
  logic [DEPTH-1:0] loop_q;
  logic [IW-1:0]    wr_idx, top_idx;

  assign empty       = (depth == '0);
  assign full        = (depth == SDW'(DEPTH));
  assign wr_idx      = IW'(depth);
  assign top_idx     = IW'(depth - SDW'(1));
  assign top_saved   = saved_q[top_idx];
  assign top_other   = other_q[top_idx];
  assign top_else_pc = else_q[top_idx];
  assign top_join    = join_q[top_idx];
  assign top_pend    = pend_q[top_idx];
  assign top_loop    = loop_q[top_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth  <= '0;
      pend_q <= '0;
      loop_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        saved_q[i] <= '0;
        other_q[i] <= '0;
        else_q[i]  <= '0;
        join_q[i]  <= '0;
      end
    end else if (clr) begin
      depth <= '0;
    end else if (push && !full) begin
      saved_q[wr_idx] <= push_saved;
      other_q[wr_idx] <= push_other;
      else_q[wr_idx]  <= push_else_pc;
      join_q[wr_idx]  <= '0;
      pend_q[wr_idx]  <= !push_loop;
      loop_q[wr_idx]  <= push_loop;
      depth           <= depth + SDW'(1);
    end else if (pop && !empty) begin
      depth <= depth - SDW'(1);
    end else if (mark && !empty) begin
      pend_q[top_idx] <= 1'b0;
      join_q[top_idx] <= mark_join;
    end
  end

endmodule

// File: rtl/simt_seq.sv
module simt_seq
  import simt_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LANES-1:0] start_mask,
  input  instr_t           ins,
  input  logic [LANES-1:0] cond_vec,
  input  logic [LANES-1:0] top_saved,
  input  logic [LANES-1:0] top_other,
  input  logic [PC_W-1:0]  top_else_pc,
  input  logic [PC_W-1:0]  top_join,
  input  logic             top_pend,
  input  logic             top_loop,
  input  logic             stk_empty,
  output logic [PC_W-1:0]  pc,
  output logic [LANES-1:0] mask,
  output logic             running,
  output logic             issue,
  output logic             push,
  output logic             pop,
  output logic             mark,
  output logic [LANES-1:0] push_saved,
  output logic [LANES-1:0] push_other,
  output logic             push_loop
);

  logic [PC_W-1:0]  pc_inc, nxt_pc;
  logic [LANES-1:0] nxt_mask, taken;
  logic             nxt_run;

  assign issue  = running;
  assign pc_inc = pc + PC_W'(1);
  assign taken  = mask & cond_vec;

  always_comb begin
    nxt_pc     = pc_inc;
    nxt_mask   = mask;
    nxt_run    = running;
    push       = 1'b0;
    pop        = 1'b0;
    mark       = 1'b0;
    push_saved = mask;
    push_other = mask & ~cond_vec;
    push_loop  = 1'b0;
    case (ins.op)
      OP_SPLIT: begin
        if (taken == '0 && mask != '0) begin
          nxt_pc = ins.imm;
        end else if (taken != mask) begin
          push     = 1'b1;
          nxt_mask = taken;
        end
      end
      OP_ELSE: begin
        if (!stk_empty && top_pend && top_else_pc == pc_inc) begin
          mark     = 1'b1;
          nxt_mask = top_other;
        end else begin
          nxt_pc = ins.imm;
        end
      end
      OP_JOIN: begin
        if (!stk_empty && !top_pend && !top_loop && top_join == pc) begin
          pop      = 1'b1;
          nxt_mask = top_saved;
        end
      end
      OP_LOPEN: begin
        push      = 1'b1;
        push_loop = 1'b1;
      end
      OP_LBACK: begin
        if (taken != '0) begin
          nxt_mask = taken;
          nxt_pc   = ins.imm;
        end else if (!stk_empty && top_loop) begin
          pop      = 1'b1;
          nxt_mask = top_saved;
        end
      end
      OP_HALT: begin
        nxt_run = 1'b0;
        nxt_pc  = pc;
      end
      default: ;
    endcase
    if (!running) begin
      nxt_pc   = pc;
      nxt_mask = mask;
      push     = 1'b0;
      pop      = 1'b0;
      mark     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc      <= '0;
      mask    <= '0;
      running <= 1'b0;
    end else if (start) begin
      pc      <= '0;
      mask    <= start_mask;
      running <= 1'b1;
    end else begin
      pc      <= nxt_pc;
      mask    <= nxt_mask;
      running <= nxt_run;
    end
  end

endmodule

// File: rtl/simt_perf.sv
module simt_perf #(
  parameter int LANES = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             issue,
  input  logic [LANES-1:0] mask,
  output logic [CNT_W-1:0] cyc_cnt,
  output logic [CNT_W-1:0] lane_sum
);

  logic [CNT_W-1:0] pop_n;

  always_comb begin
    pop_n = '0;
    for (int i = 0; i < LANES; i++) pop_n = pop_n + CNT_W'(mask[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_cnt  <= '0;
      lane_sum <= '0;
    end else if (clr) begin
      cyc_cnt  <= '0;
      lane_sum <= '0;
    end else if (issue) begin
      cyc_cnt  <= cyc_cnt + CNT_W'(1);
      lane_sum <= lane_sum + pop_n;
    end
  end

endmodule

// File: rtl/simt_warp_unit.sv
module simt_warp_unit
  import simt_pkg::*;
#(
  parameter int LANES = 32,
  parameter int NREG  = 64,
  parameter int DEPTH = 8,
  parameter int CNT_W = 32,
  localparam int LW   = $clog2(LANES),
  localparam int SDW  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LANES-1:0]  start_mask,
  input  logic [31:0]       instr,
  output logic [PC_W-1:0]   pc,
  output logic              running,
  output logic [LANES-1:0]  active_mask,
  output logic [SDW-1:0]    stack_depth,
  output logic [CNT_W-1:0]  cycle_count,
  output logic [CNT_W-1:0]  lane_count,
  input  logic [LW-1:0]     rd_lane,
  input  logic [REG_W-1:0]  rd_reg,
  output logic [DATA_W-1:0] rd_data
);

  instr_t            ins;
  logic [LANES-1:0]  cond_vec, lane_we, mask;
  logic [DATA_W-1:0] lane_dbg [LANES];
  logic              issue, push_ev, pop_ev, mark_ev, push_loop;
  logic [LANES-1:0]  push_saved, push_other;
  logic [LANES-1:0]  top_saved, top_other;
  logic [PC_W-1:0]   top_else_pc, top_join;
  logic              top_pend, top_loop, stk_empty, stk_full;
  logic              wr_any;

  assign ins         = instr_t'(instr);
  assign wr_any      = issue && op_writes(ins.op);
  assign active_mask = mask;
  assign rd_data     = lane_dbg[rd_lane];

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_we[g] = wr_any && mask[g];
      simt_lane #(.LANE_ID(g), .NREG(NREG)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (lane_we[g]),
        .ins      (ins),
        .dbg_sel  (rd_reg),
        .cond_nz  (cond_vec[g]),
        .dbg_data (lane_dbg[g])
      );
    end
  endgenerate

  simt_seq #(.LANES(LANES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_mask  (start_mask),
    .ins         (ins),
    .cond_vec    (cond_vec),
    .top_saved   (top_saved),
    .top_other   (top_other),
    .top_else_pc (top_else_pc),
    .top_join    (top_join),
    .top_pend    (top_pend),
    .top_loop    (top_loop),
    .stk_empty   (stk_empty),
    .pc          (pc),
    .mask        (mask),
    .running     (running),
    .issue       (issue),
    .push        (push_ev),
    .pop         (pop_ev),
    .mark        (mark_ev),
    .push_saved  (push_saved),
    .push_other  (push_other),
    .push_loop   (push_loop)
  );

  simt_div_stack #(.DEPTH(DEPTH), .LANES(LANES)) u_stack (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (start),
    .push         (push_ev),
    .pop          (pop_ev),
    .mark         (mark_ev),
    .push_saved   (push_saved),
    .push_other   (push_other),
    .push_else_pc (ins.imm),
    .push_loop    (push_loop),
    .mark_join    (ins.imm),
    .top_saved    (top_saved),
    .top_other    (top_other),
    .top_else_pc  (top_else_pc),
    .top_join     (top_join),
    .top_pend     (top_pend),
    .top_loop     (top_loop),
    .depth        (stack_depth),
    .empty        (stk_empty),
    .full         (stk_full)
  );

  simt_perf #(.LANES(LANES), .CNT_W(CNT_W)) u_perf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .issue    (issue),
    .mask     (mask),
    .cyc_cnt  (cycle_count),
    .lane_sum (lane_count)
  );

endmodule

// File: rtl/simt_warp_chk.sv
module simt_warp_chk
  import simt_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  parameter int CNT_W = 32,
  localparam int SDW  = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             issue,
  input logic             running,
  input logic [31:0]      instr,
  input logic [LANES-1:0] mask,
  input logic [LANES-1:0] cond_vec,
  input logic [LANES-1:0] lane_we,
  input logic [PC_W-1:0]  pc,
  input logic [SDW-1:0]   depth,
  input logic [CNT_W-1:0] cyc_cnt,
  input logic [CNT_W-1:0] lane_sum
);

  instr_t           ins;
  logic [LANES-1:0] taken;

  assign ins   = instr_t'(instr);
  assign taken = mask & cond_vec;

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !start |=> cyc_cnt == $past(cyc_cnt) + CNT_W'(1)); // R7

  AST_LANE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !start |=> lane_sum == $past(lane_sum) + CNT_W'($countones($past(mask)))); // R7

  AST_MASKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we & ~mask) == '0); // R3

  AST_UNIFORM_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !start && ins.op == OP_SPLIT && (taken == mask || taken == '0)
    |=> depth == $past(depth)); // R5

  AST_DIVERGE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !start && ins.op == OP_SPLIT && taken != '0 && taken != mask
    && depth < SDW'(DEPTH)
    |=> depth == $past(depth) + SDW'(1) && mask == $past(taken)); // R4

  AST_ZERO_MASK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !start && mask == '0 && !op_is_ctrl(ins.op)
    |=> pc == $past(pc) + PC_W'(1)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !start |=> $stable(pc) && $stable(cyc_cnt)); // R11

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= SDW'(DEPTH)); // R6

endmodule

bind simt_warp_unit simt_warp_chk #(.LANES(LANES), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .issue    (issue),
  .running  (running),
  .instr    (instr),
  .mask     (mask),
  .cond_vec (cond_vec),
  .lane_we  (lane_we),
  .pc       (pc),
  .depth    (stack_depth),
  .cyc_cnt  (cycle_count),
  .lane_sum (lane_count)
);

// File: tb/tb_simt_warp_unit.sv
module tb_simt_warp_unit;

  localparam int NL = 32;

  // Opcode values per R1
  localparam int C_ADD = 1, C_SUB = 2, C_AND = 3, C_OR = 4, C_XOR = 5, C_SLT = 6;
  localparam int C_LDI = 7, C_LID = 8, C_SPL = 9, C_ELS = 10, C_JN = 11;
  localparam int C_LOP = 12, C_LBK = 13, C_HLT = 14;

  // ALU vectors: {opcode, immediate}; lane value r1 = lane index, r2 = immediate
  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    {4'd1, 10'd7},  {4'd2, 10'd5},  {4'd2, 10'd40}, {4'd3, 10'd6},
    {4'd4, 10'd9},  {4'd5, 10'd21}, {4'd6, 10'd16}, {4'd6, 10'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_mask = '0;
  logic [31:0] instr;
  logic [9:0]  pc;
  logic        running;
  logic [31:0] active_mask;
  logic [3:0]  stack_depth;
  logic [31:0] cycle_count, lane_count;
  logic [4:0]  rd_lane = '0;
  logic [5:0]  rd_reg = '0;
  logic [31:0] rd_data;

  logic [31:0] prog [64];
  int          n_chk = 0;
  int          n_fail = 0;
  int          wd = 0;
  int          maxdep = 0;
  logic [31:0] exp_v [NL];

  always #5 clk = ~clk;
  assign instr = prog[pc[5:0]];

  simt_warp_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_mask(start_mask),
    .instr(instr), .pc(pc), .running(running), .active_mask(active_mask),
    .stack_depth(stack_depth), .cycle_count(cycle_count), .lane_count(lane_count),
    .rd_lane(rd_lane), .rd_reg(rd_reg), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] enc(int op, int rd, int a, int b, int imm);
    return {op[3:0], rd[5:0], a[5:0], b[5:0], imm[9:0]};
  endfunction

  function automatic logic [31:0] model(int op, logic [31:0] a, logic [31:0] b);
    case (op)
      C_ADD: return a + b;
      C_SUB: return a - b;
      C_AND: return a & b;
      C_OR:  return a | b;
      C_XOR: return a ^ b;
      default: return (signed'(a) < signed'(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(string tag, int r);
    int bad;
    bad = -1;
    n_chk++;
    for (int l = 0; l < NL; l++) begin
      rd_lane = l[4:0]; rd_reg = r[5:0];
      #1;
      if (rd_data !== exp_v[l] && bad < 0) bad = l;
    end
    if (bad >= 0) begin
      rd_lane = bad[4:0]; #1;
      n_fail++;
      $display("FAIL %s: lane %0d r%0d actual %0h expected %0h", tag, bad, r, rd_data, exp_v[bad]);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = enc(C_HLT, 0, 0, 0, 0);
  endtask

  task automatic run(logic [31:0] m);
    maxdep = 0;
    @(negedge clk);
    start = 1'b1; start_mask = m;
    @(negedge clk);
    start = 1'b0;
    while (running) begin
      if (int'(stack_depth) > maxdep) maxdep = int'(stack_depth);
      @(negedge clk);
    end
  endtask

  initial begin
    clear_prog();
    do_reset();

    // R9: reset state
    chk("R9 pc", 32'(pc), 0);
    chk("R9 running", 32'(running), 0);
    chk("R9 counters", cycle_count | lane_count, 0);
    chk("R9 depth", 32'(stack_depth), 0);
    for (int l = 0; l < NL; l++) exp_v[l] = 0;
    chk_reg("R9 regs", 9);

    // R1 R2: vector table walk
    for (int v = 0; v < NV; v++) begin
      clear_prog();
      prog[0] = enc(C_LID, 1, 0, 0, 0);
      prog[1] = enc(C_LDI, 2, 0, 0, int'(VEC[v][9:0]));
      prog[2] = enc(int'(VEC[v][13:10]), 3, 1, 2, 0);
      run('1);
      for (int l = 0; l < NL; l++)
        exp_v[l] = model(int'(VEC[v][13:10]), 32'(l), 32'(VEC[v][9:0]));
      chk_reg("R2 alu vector", 3);
    end

    // R4 R3: divergent if/else on odd/even lanes
    do_reset(); clear_prog();
    prog[0]  = enc(C_LID, 1, 0, 0, 0);
    prog[1]  = enc(C_LDI, 2, 0, 0, 1);
    prog[2]  = enc(C_AND, 3, 1, 2, 0);
    prog[3]  = enc(C_SPL, 0, 3, 0, 7);
    prog[4]  = enc(C_LDI, 4, 0, 0, 100);
    prog[5]  = enc(C_ADD, 5, 1, 1, 0);
    prog[6]  = enc(C_ELS, 0, 0, 0, 9);
    prog[7]  = enc(C_LDI, 4, 0, 0, 200);
    prog[8]  = enc(C_LDI, 6, 0, 0, 7);
    prog[9]  = enc(C_JN, 0, 0, 0, 0);
    prog[10] = enc(C_LDI, 7, 0, 0, 5);
    run('1);
    for (int l = 0; l < NL; l++) exp_v[l] = (l % 2) ? 100 : 200;
    chk_reg("R4 both paths", 4);
    for (int l = 0; l < NL; l++) exp_v[l] = (l % 2) ? 2 * l : 0;
    chk_reg("R3 even lanes untouched", 5);
    for (int l = 0; l < NL; l++) exp_v[l] = (l % 2) ? 0 : 7;
    chk_reg("R3 odd lanes untouched", 6);
    for (int l = 0; l < NL; l++) exp_v[l] = 5;
    chk_reg("R4 reconverged", 7);
    chk("R4 stack peak", 32'(maxdep), 1);
    chk("R4 stack empty", 32'(stack_depth), 0);
    chk("R7 cycles divergent", cycle_count, 12);
    chk("R7 lanes divergent", lane_count, 288);

    // R5: uniform split, all true then all false
    for (int t = 0; t < 2; t++) begin
      do_reset(); clear_prog();
      prog[0] = enc(C_LDI, 1, 0, 0, 1 - t);
      prog[1] = enc(C_SPL, 0, 1, 0, 4);
      prog[2] = enc(C_LDI, 2, 0, 0, 9);
      prog[3] = enc(C_ELS, 0, 0, 0, 5);
      prog[4] = enc(C_LDI, 2, 0, 0, 3);
      prog[5] = enc(C_JN, 0, 0, 0, 0);
      prog[6] = enc(C_HLT, 0, 0, 0, 0);
      run('1);
      for (int l = 0; l < NL; l++) exp_v[l] = (t == 0) ? 9 : 3;
      chk_reg("R5 single path", 2);
      chk("R5 no push", 32'(maxdep), 0);
      chk("R5 cycles", cycle_count, (t == 0) ? 6 : 5);
    end

    // R6 R7: loop with per-lane trip count (lane & 3) + 1
    do_reset(); clear_prog();
    prog[0] = enc(C_LID, 1, 0, 0, 0);
    prog[1] = enc(C_LDI, 3, 0, 0, 3);
    prog[2] = enc(C_AND, 2, 1, 3, 0);
    prog[3] = enc(C_LDI, 4, 0, 0, 1);
    prog[4] = enc(C_ADD, 2, 2, 4, 0);
    prog[5] = enc(C_LOP, 0, 0, 0, 0);
    prog[6] = enc(C_ADD, 5, 5, 4, 0);
    prog[7] = enc(C_SUB, 2, 2, 4, 0);
    prog[8] = enc(C_LBK, 0, 2, 0, 6);
    run('1);
    for (int l = 0; l < NL; l++) exp_v[l] = (l & 3) + 1;
    chk_reg("R6 per-lane trips", 5);
    for (int l = 0; l < NL; l++) exp_v[l] = 0;
    chk_reg("R6 counters drained", 2);
    chk("R6 mask restored", active_mask, 32'hFFFF_FFFF);
    chk("R6 stack popped", 32'(stack_depth), 0);
    chk("R7 cycles loop", cycle_count, 19);
    chk("R7 lanes loop", lane_count, 464);

    // R8: all-zero mask
    do_reset(); clear_prog();
    prog[0] = enc(C_LDI, 1, 0, 0, 55);
    prog[1] = enc(C_LID, 2, 0, 0, 0);
    run('0);
    for (int l = 0; l < NL; l++) exp_v[l] = 0;
    chk_reg("R8 no write", 1);
    chk("R8 pc reached halt", 32'(pc), 2);
    chk("R8 cycles", cycle_count, 3);
    chk("R8 lanes", lane_count, 0);

    // R10 R11: partial launch mask, then halt holds state
    clear_prog();
    prog[0] = enc(C_LDI, 1, 0, 0, 77);
    run(32'h0000_FFFF);
    for (int l = 0; l < NL; l++) exp_v[l] = (l < 16) ? 77 : 0;
    chk_reg("R10 launch mask", 1);
    chk("R10 counters cleared", cycle_count, 2);
    chk("R10 lanes", lane_count, 32);
    repeat (4) @(negedge clk);
    chk("R11 pc held", 32'(pc), 1);
    chk("R11 count held", cycle_count, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule